// File: doc/BRIEF.md
# Configuration Command Stream Decoder

The decoder takes a configuration stream one byte at a time over a valid/ready handshake and splits it into commands. Every command has the same header: a one-byte opcode, then a 16-bit payload length sent low byte first. The decoder compares that length with the size each command allows. It then sends each payload byte to the right sink. Memory-init data goes to a write port with an address that counts up. The die-to-die enables go to a register output. All other payload bytes go to a general payload bus that is tagged with the opcode and the byte index. Some commands must be followed by a fixed run of filler bytes. The decoder reads and checks these fillers before it accepts the next opcode.

A lock-wait command stalls the input until all the PLL lock inputs it selects are high. Any sequencing fault sets a sticky error and stops all decoding until reset. Sequencing faults are: an unknown opcode, a wrong length, a bad filler byte, or a memory burst sent before both an address and a target block exist. While in error the decoder keeps taking and discarding bytes, so the upstream source never hangs.

Opcodes: 0x01 latch reset (length 1), 0x02 memory address (2), 0x03 memory data (1..5120), 0x04 block select (1), 0x05 PLL configuration (24), 0x06 PLL select (1), 0x07 lock wait (1), 0x08 status change (12), 0x09 die-to-die (1), 0x0A configuration mode (1), 0x0B slave mode (1).

Top module: `cfg_stream_decoder`

## Requirements
- R1: After reset, inReady is 1 and errFlag, payValid, memWe and d2dEn are all 0.
- R2: A header is an opcode byte followed by a 16-bit length, low byte first. An unknown opcode, or a length that differs from the command's fixed size, sets errFlag one cycle after the offending byte is accepted.
- R3: One cycle after each accepted payload byte of a non-memory-data command, payValid pulses for one cycle. At the same time payCmd carries the opcode, payIdx the zero-based byte index and payData the byte. memWe and payValid are never high together.
- R4: The memory address command sets the start address from its two payload bytes. Byte 0 is address bits 7:0 and byte 1 is bits 15:8.
- R5: One cycle after each accepted memory-data byte, memWe pulses with memData equal to the byte and memAddr equal to the current address. The address then increases by one. Lengths from 1 to 5120 are accepted. A length of 0 or one above 5120 sets errFlag.
- R6: A memory-data header sets errFlag and produces no write if no address command has completed since reset, or if no block select command has.
- R7: Filler bytes must follow the payload before the next opcode is taken. PLL configuration needs 6 bytes of 0x00. Status change needs 9 bytes: 0x00 0x00 0x00 0x00 0x33 0x00 0x00 0x00 0x00. Configuration mode and slave mode each need 3 bytes of 0x00. Filler bytes give no payValid and no memWe.
- R8: A filler byte that differs from its expected value sets errFlag. errFlag stays set until reset.
- R9: After the payload byte of a lock-wait command (opcode 0x07), inReady stays 0 until every lock input selected by that byte's bits 3:0 is high. It returns to 1 one cycle after that condition holds.
- R10: The die-to-die payload byte drives d2dEn. Bit 0 is north, bit 1 east, bit 2 south and bit 3 west.
- R11: While errFlag is set, inReady stays 1 and every byte is discarded, with no payValid and no memWe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Stream byte present |
| inReady | output | 1 | Decoder can take a byte |
| inData | input | 8 | Stream byte |
| pllLock | input | NUM_PLL | PLL lock indications |
| payValid | output | 1 | Payload byte strobe |
| payCmd | output | 8 | Opcode of the payload byte |
| payIdx | output | clog2(MAX_BURST+1) | Index of the byte inside its payload |
| payData | output | 8 | Payload byte |
| memWe | output | 1 | Memory-init write strobe |
| memBlk | output | 8 | Selected target block |
| memAddr | output | 16 | Memory-init write address |
| memData | output | 8 | Memory-init write data |
| d2dEn | output | 4 | Die-to-die link enables (N, E, S, W) |
| errFlag | output | 1 | Sticky sequencing error |

## Verification
A wrong decoder state shows up quickly because it misclassifies the very next byte. That byte either appears on the wrong sink, or has the wrong index, or sets errFlag, one cycle after it is accepted. A counter that is off by one shows up as a filler byte or an opcode being treated as payload. So the stream is checked byte by byte, the error flag is watched throughout, and each command is followed by another command to show that the decoder went back to reading opcodes. A lost or stuck address shows up on memAddr at the first write of the next burst. A bad stall shows up on inReady within one cycle of the lock inputs changing.

// File: rtl/cfgdec_pkg.sv
package cfgdec_pkg;

  localparam logic [7:0] OP_LATCH_RST = 8'h01;
  localparam logic [7:0] OP_MEM_ADDR  = 8'h02;
  localparam logic [7:0] OP_MEM_DATA  = 8'h03;
  localparam logic [7:0] OP_BLK_SEL   = 8'h04;
  localparam logic [7:0] OP_PLL_CFG   = 8'h05;
  localparam logic [7:0] OP_PLL_SEL   = 8'h06;
  localparam logic [7:0] OP_PLL_WAIT  = 8'h07;
  localparam logic [7:0] OP_STATUS    = 8'h08;
  localparam logic [7:0] OP_D2D       = 8'h09;
  localparam logic [7:0] OP_CFG_MODE  = 8'h0A;
  localparam logic [7:0] OP_SLAVE     = 8'h0B;

  typedef enum logic [2:0] {
    S_OP, S_LEN0, S_LEN1, S_PAY, S_TRL, S_WAIT, S_ERR
  } state_e;

  // control -> datapath
  typedef struct packed {
    logic ldOp;
    logic ldLenLo;
    logic ldLenHi;
    logic payStb;
    logic trlStb;
    logic clrCnt;
  } strobe_t;

  // datapath -> control
  typedef struct packed {
    logic lenOk;
    logic payLast;
    logic trlLast;
    logic trlMatch;
    logic hasTrail;
    logic isWait;
    logic waitDone;
  } status_t;

  function automatic logic knownOp(input logic [7:0] op);
    return (op >= OP_LATCH_RST) && (op <= OP_SLAVE);
  endfunction

  // fixed payload size; memory data is range-checked separately
  function automatic logic [4:0] fixedLen(input logic [7:0] op);
    case (op)
      OP_MEM_ADDR: return 5'd2;
      OP_PLL_CFG:  return 5'd24;
      OP_STATUS:   return 5'd12;
      default:     return 5'd1;
    endcase
  endfunction

  function automatic logic [3:0] trailLen(input logic [7:0] op);
    case (op)
      OP_PLL_CFG:  return 4'd6;
      OP_STATUS:   return 4'd9;
      OP_CFG_MODE: return 4'd3;
      OP_SLAVE:    return 4'd3;
      default:     return 4'd0;
    endcase
  endfunction

  function automatic logic [7:0] trailVal(input logic [7:0] op, input logic [3:0] idx);
    return (op == OP_STATUS && idx == 4'd4) ? 8'h33 : 8'h00;
  endfunction

endpackage

// File: rtl/cfgdec_ctrl.sv
module cfgdec_ctrl
  import cfgdec_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    inValid,
  input  logic    [7:0] inData,
  input  status_t sts,
  output logic    inReady,
  output strobe_t stb,
  output logic    errFlag
);

  state_e state, nxtState;
  logic fire;

  assign inReady = (state != S_WAIT);
  assign errFlag = (state == S_ERR);
  assign fire    = inValid && inReady;

  always_comb begin
    stb      = '0;
    nxtState = state;
    case (state)
      S_OP: if (fire) begin
        if (knownOp(inData)) begin
          stb.ldOp = 1'b1;
          nxtState = S_LEN0;
        end else begin
          nxtState = S_ERR;
        end
      end
      S_LEN0: if (fire) begin
        stb.ldLenLo = 1'b1;
        nxtState    = S_LEN1;
      end
      S_LEN1: if (fire) begin
        if (sts.lenOk) begin
          stb.ldLenHi = 1'b1;
          stb.clrCnt  = 1'b1;
          nxtState    = S_PAY;
        end else begin
          nxtState = S_ERR;
        end
      end
      S_PAY: if (fire) begin
        stb.payStb = 1'b1;
        if (sts.payLast) begin
          stb.clrCnt = 1'b1;
          if (sts.hasTrail)    nxtState = S_TRL;
          else if (sts.isWait) nxtState = S_WAIT;
          else                 nxtState = S_OP;
        end
      end
      S_TRL: if (fire) begin
        if (!sts.trlMatch) begin
          nxtState = S_ERR;
        end else begin
          stb.trlStb = 1'b1;
          if (sts.trlLast) nxtState = S_OP;
        end
      end
      S_WAIT: if (sts.waitDone) nxtState = S_OP;
      default: nxtState = S_ERR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_OP;
    else       state <= nxtState;
  end

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    $past(errFlag) |-> errFlag);

  assert_stall_cause_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(inReady) |-> $past(inValid));

endmodule

// File: rtl/cfgdec_datapath.sv
module cfgdec_datapath
  import cfgdec_pkg::*;
#(
  parameter int MAX_BURST = 5120,
  parameter int NUM_PLL   = 4,
  localparam int CNT_W    = $clog2(MAX_BURST + 1),
  localparam int ADDR_W   = 16,
  localparam int SIDES    = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [7:0]          inData,
  input  logic [NUM_PLL-1:0]  pllLock,
  input  strobe_t             stb,
  output status_t             sts,
  output logic                payValid,
  output logic [7:0]          payCmd,
  output logic [CNT_W-1:0]    payIdx,
  output logic [7:0]          payData,
  output logic                memWe,
  output logic [7:0]          memBlk,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [7:0]          memData,
  output logic [SIDES-1:0]    d2dEn
);

  logic [7:0]         opReg;
  logic [7:0]         lenLo;
  logic [15:0]        lenReg;
  logic [15:0]        lenFull;
  logic [CNT_W-1:0]   cnt;
  logic [ADDR_W-1:0]  addr;
  logic               addrSet;
  logic               blkSet;
  logic [NUM_PLL-1:0] waitMask;

  assign lenFull = {inData, lenLo};

  always_comb begin
    if (opReg == OP_MEM_DATA)
      sts.lenOk = (lenFull != 16'd0) && (lenFull <= 16'(MAX_BURST)) && addrSet && blkSet;
    else
      sts.lenOk = (lenFull == 16'(fixedLen(opReg)));
    sts.payLast  = (16'(cnt) + 16'd1) == lenReg;
    sts.trlLast  = (cnt + CNT_W'(1)) == CNT_W'(trailLen(opReg));
    sts.trlMatch = (inData == trailVal(opReg, cnt[3:0]));
    sts.hasTrail = (trailLen(opReg) != 4'd0);
    sts.isWait   = (opReg == OP_PLL_WAIT);
    sts.waitDone = ((pllLock & waitMask) == waitMask);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opReg <= '0; lenLo <= '0; lenReg <= '0; cnt <= '0;
      addr <= '0; addrSet <= 1'b0; blkSet <= 1'b0; waitMask <= '0;
      payValid <= 1'b0; payCmd <= '0; payIdx <= '0; payData <= '0;
      memWe <= 1'b0; memBlk <= '0; memAddr <= '0; memData <= '0;
      d2dEn <= '0;
    end else begin
      payValid <= 1'b0;
      memWe    <= 1'b0;
      if (stb.ldOp)    opReg  <= inData;
      if (stb.ldLenLo) lenLo  <= inData;
      if (stb.ldLenHi) lenReg <= lenFull;
      if (stb.clrCnt)                    cnt <= '0;
      else if (stb.payStb || stb.trlStb) cnt <= cnt + CNT_W'(1);
      if (stb.payStb) begin
        if (opReg == OP_MEM_DATA) begin
          memWe   <= 1'b1;
          memAddr <= addr;
          memData <= inData;
          addr    <= addr + ADDR_W'(1);
        end else begin
          payValid <= 1'b1;
          payCmd   <= opReg;
          payIdx   <= cnt;
          payData  <= inData;
        end
        case (opReg)
          OP_MEM_ADDR:
            if (cnt == '0) addr[7:0] <= inData;
            else begin
              addr[15:8] <= inData;
              addrSet    <= 1'b1;
            end
          OP_BLK_SEL: begin
            memBlk <= inData;
            blkSet <= 1'b1;
          end
          OP_PLL_WAIT: waitMask <= inData[NUM_PLL-1:0];
          OP_D2D:      d2dEn    <= inData[SIDES-1:0];
          default: ;
        endcase
      end
    end
  end

  assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && $past(memWe)) |-> memAddr == $past(memAddr) + ADDR_W'(1));

  assert_one_sink_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(payValid && memWe));

  assert_mem_setup_R6: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (addrSet && blkSet));

endmodule

// File: rtl/cfg_stream_decoder.sv
module cfg_stream_decoder
  import cfgdec_pkg::*;
#(
  parameter int MAX_BURST = 5120,
  parameter int NUM_PLL   = 4
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               inValid,
  output logic                               inReady,
  input  logic [7:0]                         inData,
  input  logic [NUM_PLL-1:0]                 pllLock,
  output logic                               payValid,
  output logic [7:0]                         payCmd,
  output logic [$clog2(MAX_BURST+1)-1:0]     payIdx,
  output logic [7:0]                         payData,
  output logic                               memWe,
  output logic [7:0]                         memBlk,
  output logic [15:0]                        memAddr,
  output logic [7:0]                         memData,
  output logic [3:0]                         d2dEn,
  output logic                               errFlag
);

  strobe_t stb;
  status_t sts;

  cfgdec_ctrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .inData  (inData),
    .sts     (sts),
    .inReady (inReady),
    .stb     (stb),
    .errFlag (errFlag)
  );

  cfgdec_datapath #(
    .MAX_BURST (MAX_BURST),
    .NUM_PLL   (NUM_PLL)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .inData   (inData),
    .pllLock  (pllLock),
    .stb      (stb),
    .sts      (sts),
    .payValid (payValid),
    .payCmd   (payCmd),
    .payIdx   (payIdx),
    .payData  (payData),
    .memWe    (memWe),
    .memBlk   (memBlk),
    .memAddr  (memAddr),
    .memData  (memData),
    .d2dEn    (d2dEn)
  );

endmodule

// File: tb/tb_cfg_stream_decoder.sv
`timescale 1ns/1ps
module tb_cfg_stream_decoder;

  localparam int MAX_BURST = 5120;
  localparam int CNT_W = $clog2(MAX_BURST + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [7:0] inData = '0;
  logic [3:0] pllLock = '0;
  logic inReady, payValid, memWe, errFlag;
  logic [7:0] payCmd, payData, memBlk, memData;
  logic [CNT_W-1:0] payIdx;
  logic [15:0] memAddr;
  logic [3:0] d2dEn;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cfg_stream_decoder #(.MAX_BURST(MAX_BURST), .NUM_PLL(4)) dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inData(inData),
    .pllLock(pllLock), .payValid(payValid), .payCmd(payCmd), .payIdx(payIdx),
    .payData(payData), .memWe(memWe), .memBlk(memBlk), .memAddr(memAddr),
    .memData(memData), .d2dEn(d2dEn), .errFlag(errFlag)
  );

  // k: 0 = no strobe, 1 = payload bus (v = index), 2 = memory write (v = address)
  typedef struct packed {
    logic [7:0]  b;
    logic [1:0]  k;
    logic [7:0]  c;
    logic [15:0] v;
  } vec_t;

  localparam int NV = 61;
  localparam vec_t VECS [NV] = '{
    '{8'h01,2'd0,8'h00,16'h0000}, '{8'h01,2'd0,8'h00,16'h0000}, '{8'h00,2'd0,8'h00,16'h0000},
    '{8'hA5,2'd1,8'h01,16'h0000},
    '{8'h02,2'd0,8'h00,16'h0000}, '{8'h02,2'd0,8'h00,16'h0000}, '{8'h00,2'd0,8'h00,16'h0000},
    '{8'h34,2'd1,8'h02,16'h0000}, '{8'h12,2'd1,8'h02,16'h0001},
    '{8'h04,2'd0,8'h00,16'h0000}, '{8'h01,2'd0,8'h00,16'h0000}, '{8'h00,2'd0,8'h00,16'h0000},
    '{8'h07,2'd1,8'h04,16'h0000},
    '{8'h03,2'd0,8'h00,16'h0000}, '{8'h03,2'd0,8'h00,16'h0000}, '{8'h00,2'd0,8'h00,16'h0000},
    '{8'h11,2'd2,8'h00,16'h1234}, '{8'h22,2'd2,8'h00,16'h1235}, '{8'h33,2'd2,8'h00,16'h1236},
    '{8'h09,2'd0,8'h00,16'h0000}, '{8'h01,2'd0,8'h00,16'h0000}, '{8'h00,2'd0,8'h00,16'h0000},
    '{8'h0A,2'd1,8'h09,16'h0000},
    '{8'h0A,2'd0,8'h00,16'h0000}, '{8'h01,2'd0,8'h00,16'h0000}, '{8'h00,2'd0,8'h00,16'h0000},
    '{8'h5C,2'd1,8'h0A,16'h0000},
    '{8'h00,2'd0,8'h00,16'h0000}, '{8'h00,2'd0,8'h00,16'h0000}, '{8'h00,2'd0,8'h00,16'h0000},
    '{8'h08,2'd0,8'h00,16'h0000}, '{8'h0C,2'd0,8'h00,16'h0000}, '{8'h00,2'd0,8'h00,16'h0000},
    '{8'h80,2'd1,8'h08,16'h0000}, '{8'h81,2'd1,8'h08,16'h0001}, '{8'h82,2'd1,8'h08,16'h0002},
    '{8'h83,2'd1,8'h08,16'h0003}, '{8'h84,2'd1,8'h08,16'h0004}, '{8'h85,2'd1,8'h08,16'h0005},
    '{8'h86,2'd1,8'h08,16'h0006}, '{8'h87,2'd1,8'h08,16'h0007}, '{8'h88,2'd1,8'h08,16'h0008},
    '{8'h89,2'd1,8'h08,16'h0009}, '{8'h8A,2'd1,8'h08,16'h000A}, '{8'h8B,2'd1,8'h08,16'h000B},
    '{8'h00,2'd0,8'h00,16'h0000}, '{8'h00,2'd0,8'h00,16'h0000}, '{8'h00,2'd0,8'h00,16'h0000},
    '{8'h00,2'd0,8'h00,16'h0000}, '{8'h33,2'd0,8'h00,16'h0000}, '{8'h00,2'd0,8'h00,16'h0000},
    '{8'h00,2'd0,8'h00,16'h0000}, '{8'h00,2'd0,8'h00,16'h0000}, '{8'h00,2'd0,8'h00,16'h0000},
    '{8'h0B,2'd0,8'h00,16'h0000}, '{8'h01,2'd0,8'h00,16'h0000}, '{8'h00,2'd0,8'h00,16'h0000},
    '{8'h3C,2'd1,8'h0B,16'h0000},
    '{8'h00,2'd0,8'h00,16'h0000}, '{8'h00,2'd0,8'h00,16'h0000}, '{8'h00,2'd0,8'h00,16'h0000}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // drive one byte; returns 1 ns after the accepting edge
  task automatic sendByte(input logic [7:0] b);
    @(negedge clk);
    inValid = 1'b1;
    inData  = b;
    while (!inReady) @(negedge clk);
    @(posedge clk);
    #1;
    inValid = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    inValid = 1'b0;
    pllLock = '0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic sendHdr(input logic [7:0] op, input logic [15:0] len);
    sendByte(op);
    sendByte(len[7:0]);
    sendByte(len[15:8]);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int bad;
    doReset();
    #1;
    // R1 reset state
    chk(inReady == 1'b1 && errFlag == 1'b0 && payValid == 1'b0 && memWe == 1'b0 && d2dEn == 4'h0,
        "R1", "reset outputs", {inReady, errFlag, payValid, memWe, d2dEn}, 8'h80);

    // table walk: R3 payload bus, R4/R5 memory path, R7 fillers
    for (int i = 0; i < NV; i++) begin
      sendByte(VECS[i].b);
      case (VECS[i].k)
        2'd1: chk(payValid && !memWe && payCmd == VECS[i].c && payIdx == CNT_W'(VECS[i].v)
                  && payData == VECS[i].b, "R3", $sformatf("pay vec %0d", i),
                  {payValid, payCmd, 3'b0, payIdx, payData}, {1'b1, VECS[i].c, VECS[i].v, VECS[i].b});
        2'd2: chk(memWe && !payValid && memAddr == VECS[i].v && memData == VECS[i].b,
                  "R4 R5", $sformatf("mem vec %0d", i),
                  {memWe, memAddr, memData}, {1'b1, VECS[i].v, VECS[i].b});
        default: chk(!payValid && !memWe && !errFlag, "R7", $sformatf("quiet vec %0d", i),
                  {payValid, memWe, errFlag}, 0);
      endcase
    end
    chk(d2dEn == 4'hA, "R10", "d2d east+west", d2dEn, 4'hA);
    chk(memBlk == 8'h07, "R6", "block held", memBlk, 8'h07);

    // R7 PLL configuration: 24 bytes then 6 zero fillers
    sendHdr(8'h05, 16'd24);
    bad = 0;
    for (int i = 0; i < 24; i++) begin
      sendByte(8'(8'h40 + i));
      if (!(payValid && payCmd == 8'h05 && payIdx == CNT_W'(i))) bad++;
    end
    chk(bad == 0, "R3", "pll cfg payload indices", bad, 0);
    bad = 0;
    for (int i = 0; i < 6; i++) begin
      sendByte(8'h00);
      if (payValid || memWe || errFlag) bad++;
    end
    chk(bad == 0, "R7", "pll cfg fillers quiet", bad, 0);
    sendHdr(8'h09, 16'd1);
    sendByte(8'h05);
    chk(d2dEn == 4'h5 && !errFlag, "R10", "d2d north+south after fillers", d2dEn, 4'h5);

    // R9 lock wait on PLL0 and PLL1
    sendHdr(8'h07, 16'd1);
    sendByte(8'h03);
    chk(inReady == 1'b0, "R9", "stall entered", inReady, 0);
    repeat (3) @(posedge clk);
    @(negedge clk); pllLock = 4'b0001;
    @(posedge clk); #1;
    chk(inReady == 1'b0, "R9", "partial lock still stalls", inReady, 0);
    @(negedge clk); pllLock = 4'b0011;
    @(posedge clk); #1;
    chk(inReady == 1'b1, "R9", "full lock releases", inReady, 1);
    sendHdr(8'h01, 16'd1);
    sendByte(8'h66);
    chk(payValid && payCmd == 8'h01 && payData == 8'h66, "R3", "opcode after wait",
        payData, 8'h66);

    // R5 maximum burst with address 0x0100
    doReset();
    sendHdr(8'h02, 16'd2); sendByte(8'h00); sendByte(8'h01);
    sendHdr(8'h04, 16'd1); sendByte(8'h02);
    sendHdr(8'h03, 16'(MAX_BURST));
    chk(!errFlag, "R5", "max length accepted", errFlag, 0);
    bad = 0;
    for (int i = 0; i < MAX_BURST; i++) begin
      sendByte(8'(i));
      if (!(memWe && memAddr == 16'(16'h0100 + i) && memData == 8'(i))) bad++;
    end
    chk(bad == 0, "R5", "max burst addresses", bad, 0);
    sendHdr(8'h01, 16'd1); sendByte(8'h77);
    chk(payValid && payData == 8'h77 && !errFlag, "R5", "opcode after burst", payData, 8'h77);

    // R5 length one over the limit
    doReset();
    sendHdr(8'h02, 16'd2); sendByte(8'h00); sendByte(8'h00);
    sendHdr(8'h04, 16'd1); sendByte(8'h01);
    sendHdr(8'h03, 16'(MAX_BURST + 1));
    chk(errFlag, "R5", "over-length rejected", errFlag, 1);

    // R5 zero length
    doReset();
    sendHdr(8'h02, 16'd2); sendByte(8'h00); sendByte(8'h00);
    sendHdr(8'h04, 16'd1); sendByte(8'h01);
    sendHdr(8'h03, 16'd0);
    chk(errFlag, "R5", "zero length rejected", errFlag, 1);

    // R6 burst with nothing set up
    doReset();
    sendHdr(8'h03, 16'd1);
    chk(errFlag, "R6", "burst without address", errFlag, 1);
    sendByte(8'h99);
    chk(!memWe, "R6", "no write without setup", memWe, 0);

    // R6 address set but no block
    doReset();
    sendHdr(8'h02, 16'd2); sendByte(8'h10); sendByte(8'h00);
    sendHdr(8'h03, 16'd1);
    chk(errFlag, "R6", "burst without block", errFlag, 1);

    // R2 length mismatch and unknown opcode
    doReset();
    sendHdr(8'h09, 16'd2);
    chk(errFlag, "R2", "fixed length mismatch", errFlag, 1);
    doReset();
    sendByte(8'hFF);
    chk(errFlag, "R2", "unknown opcode", errFlag, 1);

    // R8 bad filler, R11 discard while in error
    doReset();
    sendHdr(8'h0B, 16'd1); sendByte(8'h3C); sendByte(8'h00);
    chk(!errFlag, "R7", "first filler ok", errFlag, 0);
    sendByte(8'h01);
    chk(errFlag, "R8", "bad filler flagged", errFlag, 1);
    bad = 0;
    sendHdr(8'h01, 16'd1);
    if (payValid || memWe || !inReady) bad++;
    sendByte(8'h55);
    if (payValid || memWe || !inReady) bad++;
    chk(bad == 0, "R11", "bytes discarded in error", bad, 0);
    chk(errFlag, "R8", "error sticky", errFlag, 1);
    doReset();
    #1;
    chk(!errFlag && inReady, "R8", "reset clears error", errFlag, 0);

    // R7 status filler with 0x33 misplaced
    sendHdr(8'h08, 16'd12);
    for (int i = 0; i < 12; i++) sendByte(8'h00);
    sendByte(8'h00); sendByte(8'h00); sendByte(8'h00);
    sendByte(8'h00);
    sendByte(8'h00);
    chk(errFlag, "R8", "status filler needs 0x33", errFlag, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule